// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a port I/O access may proceed. A request carries a port number, an access width of one, two or four bytes, the privilege level of the running code and the I/O privilege level that the operating system set. When the running code is privileged enough, the block grants the access at once. Otherwise it reads the bytes it needs from a permission bitmap in memory. The bitmap has one bit per port, and the block uses a configured base address and a highest valid byte address to find those bytes. It then answers with a grant or a general-protection fault.

Every port that a multi-byte access touches is checked. When the ports of one access fall into two bitmap bytes, the block reads both bytes, one per cycle. A configuration bit makes the block copy an old off-by-one flaw: in that mode a four-byte access is judged on its first three ports only. Instruction decode, the I/O bus cycle and the delivery of the fault belong to other blocks.

Top module: `ioPermCheck`

## Requirements
- R1: When `reqCpl` is numerically less than or equal to `reqIopl`, the access is granted. No memory read is issued, and the result appears two cycles after the request is accepted.
- R2: The permission bit for port p is bit p[2:0] of the byte at address `cfgBase` + (p >> 3). A bit value of 0 allows the port and a bit value of 1 blocks it.
- R3: `reqWidth` code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. The access covers that many consecutive ports starting at `reqPort`. It is granted only when every covered port is allowed.
- R4: A checked access issues one read when its checked ports lie in one bitmap byte, and the result appears three cycles after acceptance. When they span two bytes, it issues two reads on consecutive cycles, lower address first, and the result appears four cycles after acceptance. Read data is expected one cycle after `memRdEn`.
- R5: A checked access faults with no read when any bitmap byte address it needs is greater than `cfgLimit`. The result appears two cycles after acceptance.
- R6: A checked access whose covered ports would pass the highest port number faults with no read. The result appears two cycles after acceptance.
- R7: With `cfgLegacyBug` at 1, a four-byte access checks only its first three ports. The fourth port's bit has no effect on the result, and no byte is read for the fourth port alone.
- R8: `reqReady` is high only when no check is in progress. Each accepted request yields exactly one single-cycle `rspValid` pulse, and during that pulse exactly one of `rspGrant` and `rspFault` is high.
- R9: During and right after reset, `reqReady` is 1 and `rspValid` and `memRdEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; a request is taken on a cycle where both are high |
| reqPort | input | PORT_W | First port of the access |
| reqWidth | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| reqCpl | input | 2 | Privilege level of the requesting code |
| reqIopl | input | 2 | I/O privilege level |
| cfgBase | input | ADDR_W | Byte address of the bitmap's first byte |
| cfgLimit | input | ADDR_W | Highest byte address the bitmap may use |
| cfgLegacyBug | input | 1 | 1 = four-byte accesses check three ports only |
| memRdEn | output | 1 | Bitmap byte read strobe |
| memRdAddr | output | ADDR_W | Bitmap byte address |
| memRdData | input | 8 | Byte returned one cycle after the read strobe |
| rspValid | output | 1 | Result pulse |
| rspGrant | output | 1 | Access allowed |
| rspFault | output | 1 | Access refused: general-protection fault |

## Verification
A wrong value in the captured request, the lane mask or the deny flag shows up as the wrong one of grant or fault. It is visible on the single result pulse, two to four cycles after acceptance. A wrong control state shows up sooner, as a read strobe where none belongs, a second read at the wrong address, or a result pulse one cycle early or late. The bench therefore checks the verdict, the exact latency, the number of reads and every read address for each request. The expected values come from a per-port model of the bitmap.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_DONE
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture request and config, clear verdict
    logic rdHi;       // address the second bitmap byte
    logic accLo;      // fold first byte into verdict
    logic accHi;      // fold second byte into verdict
    logic forceDeny;  // pre-read fault (limit or overflow)
  } dpStrobe_t;

endpackage

// File: rtl/ioperm_datapath.sv
module ioperm_datapath
  import ioperm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [1:0]        reqWidth,
  input  logic [1:0]        reqCpl,
  input  logic [1:0]        reqIopl,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              cfgLegacyBug,
  input  logic [7:0]        memRdData,
  output logic              privOk,
  output logic              preFault,
  output logic              spansTwo,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              denied
);

  localparam int SUM_W = ADDR_W + 1;
  localparam int END_W = PORT_W + 1;

  logic [PORT_W-1:0] portQ;
  logic [1:0]        widthQ;
  logic              privQ;
  logic              legacyQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] limitQ;
  logic              deniedQ;

  logic [2:0]       fullCnt;
  logic [2:0]       chkCnt;
  logic [3:0]       laneBits;
  logic [15:0]      laneMask;
  logic [END_W-1:0] endExcl;
  logic             overflow;
  logic [SUM_W-1:0] addrLoSum;
  logic [SUM_W-1:0] addrHiSum;
  logic             loOut;
  logic             hiOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ   <= '0;
      widthQ  <= '0;
      privQ   <= 1'b0;
      legacyQ <= 1'b0;
      baseQ   <= '0;
      limitQ  <= '0;
    end else if (ctl.load) begin
      portQ   <= reqPort;
      widthQ  <= reqWidth;
      privQ   <= (reqCpl <= reqIopl);
      legacyQ <= cfgLegacyBug;
      baseQ   <= cfgBase;
      limitQ  <= cfgLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              deniedQ <= 1'b0;
    else if (ctl.load)      deniedQ <= 1'b0;
    else if (ctl.forceDeny) deniedQ <= 1'b1;
    else if (ctl.accLo)     deniedQ <= deniedQ | (|(memRdData & laneMask[7:0]));
    else if (ctl.accHi)     deniedQ <= deniedQ | (|(memRdData & laneMask[15:8]));
  end

  always_comb begin
    unique case (widthQ)
      2'd0:    fullCnt = 3'd1;
      2'd1:    fullCnt = 3'd2;
      default: fullCnt = 3'd4;
    endcase
    chkCnt = (legacyQ && fullCnt == 3'd4) ? 3'd3 : fullCnt;
    unique case (chkCnt)
      3'd1:    laneBits = 4'b0001;
      3'd2:    laneBits = 4'b0011;
      3'd3:    laneBits = 4'b0111;
      default: laneBits = 4'b1111;
    endcase
    laneMask = {12'b0, laneBits} << portQ[2:0];
  end

  assign endExcl   = {1'b0, portQ} + END_W'(fullCnt);
  assign overflow  = endExcl > {1'b1, {PORT_W{1'b0}}};
  assign addrLoSum = {1'b0, baseQ} + SUM_W'(portQ[PORT_W-1:3]);
  assign addrHiSum = addrLoSum + SUM_W'(1);
  assign loOut     = addrLoSum > {1'b0, limitQ};
  assign hiOut     = addrHiSum > {1'b0, limitQ};

  assign spansTwo  = |laneMask[15:8];
  assign preFault  = overflow | loOut | (spansTwo & hiOut);
  assign privOk    = privQ;
  assign denied    = deniedQ;
  assign memRdAddr = ctl.rdHi ? addrHiSum[ADDR_W-1:0] : addrLoSum[ADDR_W-1:0];

endmodule

// File: rtl/ioperm_control.sv
module ioperm_control
  import ioperm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      privOk,
  input  logic      preFault,
  input  logic      spansTwo,
  output logic      reqReady,
  output logic      memRdEn,
  output logic      rspValid,
  output dpStrobe_t ctl
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memRdEn   = 1'b0;
    rspValid  = 1'b0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.load  = 1'b1;
          stateNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (privOk) begin
          stateNext = ST_DONE;
        end else if (preFault) begin
          ctl.forceDeny = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          memRdEn   = 1'b1;
          stateNext = ST_WAIT_LO;
        end
      end
      ST_WAIT_LO: begin
        ctl.accLo = 1'b1;
        if (spansTwo) begin
          memRdEn   = 1'b1;
          ctl.rdHi  = 1'b1;
          stateNext = ST_WAIT_HI;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_WAIT_HI: begin
        ctl.accHi = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ioPermCheck.sv
module ioPermCheck
  import ioperm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [1:0]        reqWidth,
  input  logic [1:0]        reqCpl,
  input  logic [1:0]        reqIopl,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              cfgLegacyBug,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault
);

  dpStrobe_t ctl;
  logic privOk, preFault, spansTwo, denied;

  ioperm_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .privOk   (privOk),
    .preFault (preFault),
    .spansTwo (spansTwo),
    .reqReady (reqReady),
    .memRdEn  (memRdEn),
    .rspValid (rspValid),
    .ctl      (ctl)
  );

  ioperm_datapath #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqPort      (reqPort),
    .reqWidth     (reqWidth),
    .reqCpl       (reqCpl),
    .reqIopl      (reqIopl),
    .cfgBase      (cfgBase),
    .cfgLimit     (cfgLimit),
    .cfgLegacyBug (cfgLegacyBug),
    .memRdData    (memRdData),
    .privOk       (privOk),
    .preFault     (preFault),
    .spansTwo     (spansTwo),
    .memRdAddr    (memRdAddr),
    .denied       (denied)
  );

  assign rspGrant = rspValid & ~denied;
  assign rspFault = rspValid & denied;

endmodule

// File: rtl/ioperm_checker.sv
module ioperm_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqCpl,
  input logic [1:0]        reqIopl,
  input logic [ADDR_W-1:0] cfgLimit,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              rspValid,
  input logic              rspGrant,
  input logic              rspFault
);

  logic acceptPriv;
  assign acceptPriv = reqValid && reqReady && (reqCpl <= reqIopl);

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspGrant ^ rspFault));

  p_quiet_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspGrant && !rspFault));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_idle_after_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (reqReady && !rspValid));

  p_priv_no_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    acceptPriv |=> !memRdEn);

  p_priv_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    acceptPriv |=> ##1 (rspValid && rspGrant));

  p_read_in_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr <= cfgLimit));

  p_read_while_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !reqReady);

  p_second_read_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memRdAddr == ADDR_W'($past(memRdAddr) + 1'b1)));

endmodule

bind ioPermCheck ioperm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqCpl    (reqCpl),
  .reqIopl   (reqIopl),
  .cfgLimit  (cfgLimit),
  .memRdEn   (memRdEn),
  .memRdAddr (memRdAddr),
  .rspValid  (rspValid),
  .rspGrant  (rspGrant),
  .rspFault  (rspFault)
);

// File: tb/tb_ioPermCheck.sv
module tb_ioPermCheck;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqPort = '0;
  logic [1:0]  reqWidth = '0;
  logic [1:0]  reqCpl = '0;
  logic [1:0]  reqIopl = '0;
  logic [15:0] cfgBase = '0;
  logic [15:0] cfgLimit = 16'hFFFF;
  logic        cfgLegacyBug = 1'b0;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic        rspValid, rspGrant, rspFault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // bitmap model: 0 all allow, 1 all deny, 2 hashed, 3 selected ports deny
  int patMode = 0;
  int patSeed = 0;
  int denyA = -1;
  int denyB = -1;

  int rdCount = 0;
  int rdAddr[2];

  always #10 clk = ~clk;

  ioPermCheck dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPort(reqPort), .reqWidth(reqWidth), .reqCpl(reqCpl), .reqIopl(reqIopl),
    .cfgBase(cfgBase), .cfgLimit(cfgLimit), .cfgLegacyBug(cfgLegacyBug),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspFault(rspFault)
  );

  function automatic bit portDenied(int p);
    int a;
    logic [31:0] h;
    a = int'(cfgBase) + (p >> 3);
    case (patMode)
      0: return 1'b0;
      1: return 1'b1;
      3: return (p == denyA) || (p == denyB);
      default: begin
        h = (32'(a) * 32'h9E3779B1) ^ 32'(patSeed);
        h = h ^ (h >> 13);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 16);
        return h[p % 8] & h[8 + p % 8] & h[16 + p % 8];
      end
    endcase
  endfunction

  function automatic logic [7:0] bmByte(int addr);
    logic [7:0] b;
    int first;
    first = (addr - int'(cfgBase)) * 8;
    for (int i = 0; i < 8; i++) b[i] = portDenied(first + i);
    return b;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= bmByte(int'(memRdAddr));
      if (rdCount < 2) rdAddr[rdCount] = int'(memRdAddr);
      rdCount = rdCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles >= 100000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: verdict, reads and read addresses from the requirements
  task automatic expect_req(input int port, input int wcode, input int cpl, input int iopl,
                            input bit legacy, output bit grant, output int nReads,
                            output int a0, output int a1);
    int n, cnt, b0, bl;
    grant = 1; nReads = 0; a0 = 0; a1 = 0;
    if (cpl <= iopl) return;
    n = (wcode == 0) ? 1 : (wcode == 1) ? 2 : 4;
    if (port + n - 1 > 65535) begin grant = 0; return; end
    cnt = (legacy && n == 4) ? 3 : n;
    b0 = port >> 3;
    bl = (port + cnt - 1) >> 3;
    a0 = int'(cfgBase) + b0;
    a1 = int'(cfgBase) + bl;
    if (a0 > int'(cfgLimit) || a1 > int'(cfgLimit)) begin grant = 0; return; end
    nReads = (bl != b0) ? 2 : 1;
    for (int i = 0; i < cnt; i++) if (portDenied(port + i)) grant = 0;
  endtask

  task automatic run_one(string req, int port, int wcode, int cpl, int iopl, bit legacy);
    bit expGrant;
    int expReads, ea0, ea1, k;
    cfgLegacyBug = legacy;
    expect_req(port, wcode, cpl, iopl, legacy, expGrant, expReads, ea0, ea1);
    @(negedge clk);
    reqPort = 16'(port); reqWidth = 2'(wcode); reqCpl = 2'(cpl); reqIopl = 2'(iopl);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    rdCount = 0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R8", "ready low while busy", int'(reqReady), 0);
    k = 1;
    while (!rspValid && k < 12) begin @(negedge clk); k++; end
    check(req, "grant", int'(rspGrant), int'(expGrant));
    check(req, "fault", int'(rspFault), int'(!expGrant));
    check("R4", "result latency", k, 2 + expReads);
    check(req, "read count", rdCount, expReads);
    if (expReads >= 1 && rdCount >= 1) check("R2", "first read address", rdAddr[0], ea0);
    if (expReads == 2 && rdCount == 2) check("R4", "second read address", rdAddr[1], ea1);
    @(negedge clk);
    check("R8", "single result pulse", int'(rspValid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reqReady in reset", int'(reqReady), 1);
    check("R9", "rspValid in reset", int'(rspValid), 0);
    check("R9", "memRdEn in reset", int'(memRdEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "reqReady after reset", int'(reqReady), 1);
    check("R9", "memRdEn after reset", int'(memRdEn), 0);

    cfgBase = 16'h1000; cfgLimit = 16'h3000;

    // R1: privileged code needs no bitmap, even one that blocks everything
    patMode = 1;
    run_one("R1", 16'h0060, 2, 0, 3, 0);
    run_one("R1", 16'h0021, 0, 3, 3, 0);
    run_one("R1", 16'hFFFF, 2, 1, 2, 0);

    // R2: bit position and polarity
    patMode = 3; denyA = 16'h123; denyB = -1;
    run_one("R2", 16'h123, 0, 3, 0, 0);
    run_one("R2", 16'h122, 0, 3, 0, 0);
    run_one("R2", 16'h124, 0, 3, 0, 0);

    // R3: every covered port, all width codes
    run_one("R3", 16'h122, 1, 3, 0, 0);
    run_one("R3", 16'h120, 2, 3, 0, 0);
    run_one("R3", 16'h120, 3, 3, 0, 0);
    run_one("R3", 16'h11F, 3, 3, 1, 0);
    run_one("R3", 16'h11E, 2, 2, 0, 0);

    // R4: span across two bitmap bytes
    patMode = 0;
    run_one("R4", 16'h3FE, 2, 3, 0, 0);
    run_one("R4", 16'h3F7, 1, 3, 0, 0);
    patMode = 3; denyA = 16'h400;
    run_one("R4", 16'h3FD, 2, 3, 0, 0);

    // R5: bitmap limit
    patMode = 0; cfgBase = 16'h1000; cfgLimit = 16'h107F;
    run_one("R5", 16'h3F8, 2, 3, 0, 0);
    run_one("R5", 16'h400, 0, 3, 0, 0);
    run_one("R5", 16'h3FE, 1, 3, 0, 0);
    run_one("R5", 16'h3FC, 2, 3, 0, 0);
    cfgBase = 16'hFFF0; cfgLimit = 16'hFFFF;
    run_one("R5", 16'h0080, 0, 3, 0, 0);

    // R6: access past the highest port
    cfgBase = 16'h0000; cfgLimit = 16'hFFFF;
    run_one("R6", 16'hFFFE, 2, 3, 0, 0);
    run_one("R6", 16'hFFFF, 1, 3, 0, 0);
    run_one("R6", 16'hFFFC, 2, 3, 0, 0);
    run_one("R6", 16'hFFFD, 2, 3, 0, 1);

    // R7: legacy off-by-one
    patMode = 3; denyA = 16'h3FB; denyB = -1;
    run_one("R7", 16'h3F8, 2, 3, 0, 0);
    run_one("R7", 16'h3F8, 2, 3, 0, 1);
    denyA = 16'h3FA;
    run_one("R7", 16'h3F8, 2, 3, 0, 1);
    denyA = 16'h400;
    run_one("R7", 16'h3FD, 2, 3, 0, 1);
    run_one("R7", 16'h3FD, 2, 3, 0, 0);
    run_one("R7", 16'h3FD, 1, 3, 0, 1);

    // R3 and the rest: random traffic against the model
    patMode = 2;
    for (int i = 0; i < 400; i++) begin
      int p;
      patSeed = int'($urandom);
      cfgBase = 16'($urandom_range(0, 16'hF000));
      cfgLimit = ($urandom_range(0, 3) == 0) ? 16'(int'(cfgBase) + $urandom_range(0, 16'h2000))
                                               : 16'hFFFF;
      case ($urandom_range(0, 3))
        0: p = 16'hFFF8 + $urandom_range(0, 7);
        1: p = ($urandom_range(0, 16'h1FFF) << 3) + 5 + $urandom_range(0, 2);
        default: p = $urandom_range(0, 16'hFFFF);
      endcase
      run_one("R3", p, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
              1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule